// File: doc/BRIEF.md
# Synchronous Burst Data SRAM with Wrap Counter

This block is the data store of a processor's secondary cache: a single-port, clocked array of 2^ADDR_W words of DATA_W bits (64 by default). An access starts when the active-low address strobe is sampled low. The address at that edge is captured. While the strobe stays high, an active-low count enable moves the access through a four-beat burst. If count enable is high as well, the access is suspended and the current word is used again.

An internal two-bit beat counter replaces only the two lowest address bits. The upper bits stay as captured. The step order is linear (add one, modulo four) or interleaved (starting low bits XOR beat number), chosen by a static order input. Writes happen on the clock edge whenever the active-low write enable is sampled low. Read data is registered. It is driven only while the asynchronous active-low output enable is low. The bus is modelled as separate input, output and output-valid ports. A strobe taken while the deselect input is high puts the block into standby. In standby it makes no access and keeps the bus released until the next accepted strobe.

Top module: `burst_sram`

## Requirements
- R1: While reset is low and after it, until a strobe is accepted, `data_oe` is 0. Count enable and write enable alone start no access.
- R2: Strobe low with `desel` low at an edge loads `addr` and starts an access there. For a read, `data_out` holds that word from the edge onward, and `data_oe` equals the inverse of `out_en_n`.
- R3: With `burst_order` = 0, each count-enabled edge steps the low two bits by +1 modulo 4 from the start value (start 01 gives 01, 10, 11, 00).
- R4: With `burst_order` = 1, beat n uses the start low bits XOR n (start 01 gives 01, 00, 11, 10).
- R5: Strobe and count enable both high at an edge suspend the access. The same word is read or written again and the beat does not advance.
- R6: Write enable low at an edge stores `data_in` at that edge's burst address. In the following cycle `data_oe` is 0 whatever `out_en_n` is.
- R7: `out_en_n` acts without the clock. Raising it releases the bus, and lowering it during a read drives the bus again, both within the same clock period.
- R8: Strobe low with `desel` high at an edge enters standby. `data_oe` stays 0, and later count-enabled edges write nothing until a strobe with `desel` low is accepted.
- R9: After the fourth beat the counter wraps, so the fifth beat addresses the same word as the first.
- R10: Bits above the low two never change during a burst. A burst started at low bits 01 of a block ending at 11 never reaches the next block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| addr | input | ADDR_W | External word address, loaded on an accepted strobe |
| addr_strobe_n | input | 1 | Active-low address strobe |
| count_en_n | input | 1 | Active-low burst advance |
| desel | input | 1 | High with the strobe selects standby |
| wr_en_n | input | 1 | Active-low write enable, sampled at every edge |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| burst_order | input | 1 | 0 linear, 1 interleaved |
| data_in | input | DATA_W | Write data |
| data_out | output | DATA_W | Read data, 0 while not driven |
| data_oe | output | 1 | High when `data_out` drives the bus |

## Verification
Each edge sets the address, and the read word is visible a delay of one time unit after that same edge. Writes are visible only through a later read. The output valid follows `out_en_n` in the same cycle, with no clock edge involved. The bench runs its own model on the same edge and compares it with the outputs one unit after every rising edge, before it changes any input. The asynchronous enable is also checked half a period into a cycle, with no edge in between. Directed checks compare burst words against constant patterns, which also confirms the address orders, the wrap, suspend and standby.

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              addr_strobe_n,
  input  logic              count_en_n,
  input  logic              desel,
  input  logic              wr_en_n,
  input  logic              out_en_n,
  input  logic              burst_order,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_q;
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] eff_addr;
  logic [1:0]        beat, beat_nxt, low;
  logic              active, rd_vld;

  wire load = !addr_strobe_n;
  wire cont = !load && active;
  wire step = cont && !count_en_n;
  wire go   = (load && !desel) || cont;

  assign beat_nxt = step ? beat + 2'd1 : beat;
  assign low      = burst_order ? (base[1:0] ^ beat_nxt) : (base[1:0] + beat_nxt);
  assign eff_addr = load ? addr : {base[ADDR_W-1:2], low};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      rd_vld <= 1'b0;
      beat   <= 2'd0;
      base   <= '0;
    end else begin
      if (load) begin
        active <= !desel;
        base   <= addr;
        beat   <= 2'd0;
      end else begin
        beat <= beat_nxt;
      end
      rd_vld <= go && wr_en_n;
    end
  end

  always_ff @(posedge clk) begin
    if (go && !wr_en_n) mem[eff_addr] <= data_in;
    if (go && wr_en_n)  rd_q <= mem[eff_addr];
  end

  assign data_oe  = rd_vld && !out_en_n;
  assign data_out = data_oe ? rd_q : '0;
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              addr_strobe_n,
  input logic              count_en_n,
  input logic              desel,
  input logic              wr_en_n,
  input logic              out_en_n,
  input logic [DATA_W-1:0] data_out,
  input logic              data_oe
);
  a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |=> !data_oe);

  a_r2_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_strobe_n && !desel && wr_en_n) |=> (data_oe == !out_en_n));

  a_r5_suspend_same: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && addr_strobe_n && count_en_n && wr_en_n) |=> (!data_oe || $stable(data_out)));

  a_r6_write_releases: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_n |=> !data_oe);

  a_r7_oe_gates: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> !data_oe);

  a_r8_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_strobe_n && desel) |=> !data_oe);
endmodule

bind burst_sram burst_sram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_strobe_n(addr_strobe_n), .count_en_n(count_en_n),
  .desel(desel), .wr_en_n(wr_en_n), .out_en_n(out_en_n), .data_out(data_out),
  .data_oe(data_oe)
);

// File: tb/tb_burst_sram.sv
`timescale 1ns/1ps
module tb_burst_sram;
  localparam int AW = 10;
  localparam int DW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic strobe_n = 1'b1, cnt_n = 1'b1, desel = 1'b0, we_n = 1'b1, oe_n = 1'b0, order = 1'b0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] data_out;
  logic data_oe;

  int checks = 0, errors = 0;
  string cur = "R1";
  bit done = 0;

  always #2 clk = ~clk;

  burst_sram #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .addr_strobe_n(strobe_n), .count_en_n(cnt_n),
    .desel(desel), .wr_en_n(we_n), .out_en_n(oe_n), .burst_order(order),
    .data_in(din), .data_out(data_out), .data_oe(data_oe));

  // behavioural reference
  logic [DW-1:0] mm [0:(1<<AW)-1];
  bit m_act = 0, m_vld = 0;
  int m_base = 0, m_n = 0;
  logic [DW-1:0] m_q = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_vld = 0; m_n = 0;
    end else begin
      int ea;
      bit use_it;
      use_it = 0; ea = 0;
      if (!strobe_n) begin
        m_act = !desel; m_base = addr; m_n = 0; ea = addr; use_it = m_act;
      end else if (m_act) begin
        if (!cnt_n) m_n = (m_n + 1) % 4;
        if (order) ea = (m_base & ~3) | ((m_base & 3) ^ m_n);
        else       ea = (m_base & ~3) | (((m_base & 3) + m_n) % 4);
        use_it = 1;
      end
      if (use_it && !we_n) mm[ea] = din;
      m_vld = use_it && we_n;
      if (m_vld) m_q = mm[ea];
    end
  end

  function automatic logic [DW-1:0] pat(int a, int salt);
    return {32'hC0DE_0000 + a[31:0] + salt[31:0], ~(a[31:0] * 32'h9E37 + salt[31:0])};
  endfunction

  task automatic compare();
    bit e_oe;
    e_oe = m_vld && !oe_n;
    checks++;
    if (data_oe !== e_oe || (e_oe && data_out !== m_q)) begin
      errors++;
      $display("FAIL %s model: oe=%0b data=%h expected oe=%0b data=%h", cur, data_oe, data_out, e_oe, m_q);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1; compare();
  endtask

  task automatic expect_word(string tag, logic [DW-1:0] exp);
    checks++;
    if (data_oe !== 1'b1 || data_out !== exp) begin
      errors++;
      $display("FAIL %s direct: oe=%0b data=%h expected oe=1 data=%h", tag, data_oe, data_out, exp);
    end
  endtask

  task automatic expect_off(string tag);
    checks++;
    if (data_oe !== 1'b0) begin
      errors++;
      $display("FAIL %s direct: oe=%0b expected oe=0", tag, data_oe);
    end
  endtask

  task automatic begin_acc(int a, bit w, logic [DW-1:0] d);
    strobe_n = 0; cnt_n = 1; desel = 0; we_n = !w; addr = a[AW-1:0]; din = d; tick();
  endtask

  task automatic next_beat(bit w, logic [DW-1:0] d);
    strobe_n = 1; cnt_n = 0; we_n = !w; din = d; tick();
  endtask

  task automatic hold_beat(bit w, logic [DW-1:0] d);
    strobe_n = 1; cnt_n = 1; we_n = !w; din = d; tick();
  endtask

  task automatic idle();
    strobe_n = 1; cnt_n = 1; we_n = 1; tick();
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset and no access before a strobe
    cur = "R1";
    repeat (3) tick();
    expect_off("R1");
    rst_n = 1;
    cnt_n = 0; we_n = 1; tick(); tick();
    expect_off("R1");
    idle();

    // R3: linear write burst at 0x011 -> 011,012,013,010
    cur = "R3"; order = 0;
    begin_acc(32'h011, 1, pat(32'h011, 1));
    next_beat(1, pat(32'h012, 1));
    next_beat(1, pat(32'h013, 1));
    next_beat(1, pat(32'h010, 1));
    idle();

    // R2 / R3 / R9: linear read from 0x012 -> 012,013,010,011,012
    cur = "R2"; begin_acc(32'h012, 0, '0); expect_word("R2", pat(32'h012, 1));
    cur = "R3"; next_beat(0, '0); expect_word("R3", pat(32'h013, 1));
    next_beat(0, '0); expect_word("R3", pat(32'h010, 1));
    next_beat(0, '0); expect_word("R3", pat(32'h011, 1));
    cur = "R9"; next_beat(0, '0); expect_word("R9", pat(32'h012, 1));
    idle();

    // R4: interleaved write at 0x022 -> 022,023,020,021
    cur = "R4"; order = 1;
    begin_acc(32'h022, 1, pat(32'h022, 2));
    next_beat(1, pat(32'h023, 2));
    next_beat(1, pat(32'h020, 2));
    next_beat(1, pat(32'h021, 2));
    idle();
    // interleaved read from 0x023 -> 023,022,021,020, wrap to 023
    begin_acc(32'h023, 0, '0); expect_word("R4", pat(32'h023, 2));
    next_beat(0, '0); expect_word("R4", pat(32'h022, 2));
    next_beat(0, '0); expect_word("R4", pat(32'h021, 2));
    next_beat(0, '0); expect_word("R4", pat(32'h020, 2));
    cur = "R9"; next_beat(0, '0); expect_word("R9", pat(32'h023, 2));
    idle();

    // R5: suspend keeps the word, then resumes in order
    cur = "R5"; order = 0;
    begin_acc(32'h011, 0, '0); expect_word("R5", pat(32'h011, 1));
    hold_beat(0, '0); expect_word("R5", pat(32'h011, 1));
    hold_beat(0, '0); expect_word("R5", pat(32'h011, 1));
    next_beat(0, '0); expect_word("R5", pat(32'h012, 1));
    // suspended write rewrites the current word
    hold_beat(1, pat(32'h012, 7));
    hold_beat(0, '0); expect_word("R5", pat(32'h012, 7));

    // R7: output enable acts within the cycle, without an edge
    cur = "R7";
    #0.5 oe_n = 1; #0.5; expect_off("R7");
    oe_n = 0; #0.5; expect_word("R7", pat(32'h012, 7));
    #0.5;
    idle();

    // R6: write with output enable low leaves the bus released
    cur = "R6"; oe_n = 0;
    begin_acc(32'h040, 1, pat(32'h040, 3)); expect_off("R6");
    next_beat(1, pat(32'h041, 3)); expect_off("R6");
    begin_acc(32'h041, 0, '0); expect_word("R6", pat(32'h041, 3));
    idle();

    // R8: standby, count/write edges do nothing
    cur = "R8";
    strobe_n = 0; desel = 1; addr = 10'h040; we_n = 1; tick(); expect_off("R8");
    desel = 0;
    next_beat(1, pat(32'h099, 9)); expect_off("R8");
    next_beat(1, pat(32'h099, 9)); expect_off("R8");
    next_beat(0, '0); expect_off("R8");
    begin_acc(32'h040, 0, '0); expect_word("R8", pat(32'h040, 3));
    next_beat(0, '0); expect_word("R8", pat(32'h041, 3));
    next_beat(0, '0); expect_word("R8", pat(32'h010, 1) ^ pat(32'h010, 1) ^ mm[32'h042]);
    idle();

    // R10: burst near a block end keeps upper bits
    cur = "R10"; order = 0;
    begin_acc(32'h100, 1, pat(32'h100, 5)); idle();
    begin_acc(32'h0FD, 1, pat(32'h0FD, 4));
    next_beat(1, pat(32'h0FE, 4));
    next_beat(1, pat(32'h0FF, 4));
    next_beat(1, pat(32'h0FC, 4));
    idle();
    begin_acc(32'h100, 0, '0); expect_word("R10", pat(32'h100, 5));
    begin_acc(32'h0FF, 0, '0); expect_word("R10", pat(32'h0FF, 4));
    next_beat(0, '0); expect_word("R10", pat(32'h0FC, 4));
    idle();

    // R1: reset in the middle of a burst ends it
    cur = "R1";
    begin_acc(32'h0FD, 0, '0); expect_word("R1", pat(32'h0FD, 4));
    rst_n = 0; next_beat(0, '0); expect_off("R1");
    rst_n = 1; next_beat(0, '0); expect_off("R1");
    idle();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule